// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block turns one multi-register load into a series of single-register writes. The caller gives it an operation kind, a target register index, a base register index, a start address and the byte order. Two kinds of operation exist. A word-multiple load fills every register from the target index up to the last register, one 4-byte word each. A quadword load fills an even/odd register pair from two 8-byte reads.

The sequencer checks the operation when it is accepted. A bad register combination is reported as an invalid form. A word-multiple load in little-endian mode is reported as an alignment error. In both cases the operation ends at once, with no memory traffic. A valid operation issues its reads one at a time through a valid/ready request channel and waits for each response. Each response becomes one register write with an index and a 64-bit value. A single-cycle done pulse closes every operation.

Top module: `mrl_load_seq`

## Requirements
- R1: A start is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance up to and including the `done_o` cycle. A start raised while busy is ignored.
- R2: A valid word-multiple load (`op_i`=0) issues 32−`tgt_idx_i` requests with `mem_req_dword_o`=0, at addresses `addr_i`, +4, +8, and so on. It writes registers `tgt_idx_i` through 31 in ascending order.
- R3: Each word-multiple write carries `mem_rsp_data_i[31:0]` in bits 31:0, and bits 63:32 are zero whatever the response's upper half holds.
- R4: A word-multiple load is invalid when `base_idx_i` is 0 or `base_idx_i` ≥ `tgt_idx_i`. The block then raises `invalid_o` with `done_o` one cycle after acceptance, and makes no request and no write.
- R5: A word-multiple load with `little_endian_i`=1 raises `align_err_o` with `done_o` one cycle after acceptance, with no request and no write. This takes precedence over R4, and `invalid_o` stays low.
- R6: A valid quadword load (`op_i`=1) requests `addr_i`, then `addr_i`+8, each with `mem_req_dword_o`=1. In big-endian mode the first response is written unchanged to `tgt_idx_i` and the second to `tgt_idx_i`+1.
- R7: In little-endian mode a quadword load uses the same request order. The first response, byte-reversed, goes to `tgt_idx_i`+1. The second, byte-reversed, goes to `tgt_idx_i`. Byte reversal swaps byte i with byte 7−i.
- R8: A quadword load is invalid when `tgt_idx_i` is odd or equals `base_idx_i`, including both being 0. This behaves like R4, while base 0 alone is allowed.
- R9: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address and size hold. At most one request is outstanding, and `mem_rsp_valid_i` outside an awaited response is ignored.
- R10: `wr_en_o` pulses in the cycle after an accepted response. `done_o` is a one-cycle pulse that coincides with the last write. `invalid_o` and `align_err_o` are high only during `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 1 | 0 word-multiple, 1 quadword |
| little_endian_i | input | 1 | Byte order, 1 little-endian |
| tgt_idx_i | input | 5 | First target register index |
| base_idx_i | input | 5 | Base register index used in form checks |
| addr_i | input | AW | Start address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (pulse) |
| invalid_o | output | 1 | Invalid form, valid with done |
| align_err_o | output | 1 | Alignment error, valid with done |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | AW | Read address |
| mem_req_dword_o | output | 1 | 1 for 8-byte read, 0 for 4-byte read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | XLEN | Read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register write index |
| wr_data_o | output | XLEN | Register write value |

## Verification
The hardest case is the little-endian quadword. There the first read lands in the higher register, so a design that swaps the data but keeps the index order still writes plausible values. The bench fills memory with values that differ in every byte and vary with the address. It checks each write's index against the response order, and it stalls the request channel and varies response latency, so an ordering or hold fault shows up. A start pulsed mid-operation and a stray response while idle test that unwanted inputs are ignored.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mrl_form_check.sv
module mrl_form_check #(
  parameter int REG_CNT = 32,
  parameter int IDX_W   = 5
) (
  input  logic             quad_i,
  input  logic             le_i,
  input  logic [IDX_W-1:0] tgt_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             invalid_o,
  output logic             align_o,
  output logic [IDX_W:0]   count_o
);
  localparam logic [IDX_W:0] REG_CNT_W = REG_CNT[IDX_W:0];

  logic bad_multi, bad_quad;

  assign bad_multi = (base_i == '0) || (base_i >= tgt_i);
  assign bad_quad  = tgt_i[0] || (tgt_i == base_i);
  assign align_o   = !quad_i && le_i;
  assign invalid_o = !align_o && (quad_i ? bad_quad : bad_multi);
  assign count_o   = quad_i ? (IDX_W+1)'(2) : (REG_CNT_W - {1'b0, tgt_i});
endmodule

// File: rtl/mrl_beat_fmt.sv
module mrl_beat_fmt #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] data_i,
  input  logic            quad_i,
  input  logic            le_i,
  output logic [XLEN-1:0] data_o
);
  localparam int NB   = XLEN / 8;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev[b*8 +: 8] = data_i[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    if (!quad_i)   data_o = {{HALF{1'b0}}, data_i[HALF-1:0]};
    else if (le_i) data_o = rev;
    else           data_o = data_i;
  end
endmodule

// File: rtl/mrl_load_seq.sv
module mrl_load_seq #(
  parameter int AW      = 32,
  parameter int XLEN    = 64,
  parameter int REG_CNT = 32,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic             little_endian_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [AW-1:0]    addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             invalid_o,
  output logic             align_err_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [AW-1:0]    mem_req_addr_o,
  output logic             mem_req_dword_o,
  input  logic             mem_rsp_valid_i,
  input  logic [XLEN-1:0]  mem_rsp_data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]  wr_data_o
);
  import mrl_pkg::*;

  localparam logic [AW-1:0] STEP_W = AW'(4);
  localparam logic [AW-1:0] STEP_D = AW'(8);

  seq_state_e       state_q;
  logic [AW-1:0]    addr_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   left_q;
  logic             quad_q, le_q;
  logic             inv_q, aln_q;
  logic             wr_en_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [XLEN-1:0]  wr_data_q;

  logic             chk_invalid, chk_align;
  logic [IDX_W:0]   chk_count;
  logic [XLEN-1:0]  fmt_data;
  logic             accept;
  logic             reverse_order;

  mrl_form_check #(.REG_CNT(REG_CNT), .IDX_W(IDX_W)) u_check (
    .quad_i   (op_i),
    .le_i     (little_endian_i),
    .tgt_i    (tgt_idx_i),
    .base_i   (base_idx_i),
    .invalid_o(chk_invalid),
    .align_o  (chk_align),
    .count_o  (chk_count)
  );

  mrl_beat_fmt #(.XLEN(XLEN)) u_fmt (
    .data_i(mem_rsp_data_i),
    .quad_i(quad_q),
    .le_i  (le_q),
    .data_o(fmt_data)
  );

  assign accept        = start_i && (state_q == ST_IDLE);
  // little-endian quad: first beat (lower address) targets the odd register
  assign reverse_order = quad_q && le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      quad_q    <= 1'b0;
      le_q      <= 1'b0;
      inv_q     <= 1'b0;
      aln_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= addr_i;
            quad_q <= op_i;
            le_q   <= little_endian_i;
            left_q <= chk_count;
            idx_q  <= (op_i && little_endian_i) ? tgt_idx_i + IDX_W'(1) : tgt_idx_i;
            if (chk_invalid || chk_align) begin
              inv_q   <= chk_invalid;
              aln_q   <= chk_align;
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            wr_en_q   <= 1'b1;
            wr_idx_q  <= idx_q;
            wr_data_q <= fmt_data;
            idx_q     <= reverse_order ? idx_q - IDX_W'(1) : idx_q + IDX_W'(1);
            addr_q    <= addr_q + (quad_q ? STEP_D : STEP_W);
            left_q    <= left_q - (IDX_W+1)'(1);
            state_q   <= (left_q == (IDX_W+1)'(1)) ? ST_FIN : ST_REQ;
          end
        end
        ST_FIN: begin
          inv_q   <= 1'b0;
          aln_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_FIN);
  assign invalid_o       = inv_q;
  assign align_err_o     = aln_q;
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = addr_q;
  assign mem_req_dword_o = quad_q;
  assign wr_en_o         = wr_en_q;
  assign wr_idx_o        = wr_idx_q;
  assign wr_data_o       = wr_data_q;
endmodule

// File: rtl/mrl_seq_chk.sv
module mrl_seq_chk #(
  parameter int AW    = 32,
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             op_i,
  input logic             little_endian_i,
  input logic [IDX_W-1:0] tgt_idx_i,
  input logic [IDX_W-1:0] base_idx_i,
  input logic [AW-1:0]    addr_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             invalid_o,
  input logic             align_err_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [AW-1:0]    mem_req_addr_o,
  input logic             mem_req_dword_o,
  input logic             mem_rsp_valid_i,
  input logic [XLEN-1:0]  mem_rsp_data_i,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [XLEN-1:0]  wr_data_o
);
  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_multi_base0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !op_i && !little_endian_i && base_idx_i == '0)
      |=> (done_o && invalid_o && !mem_req_valid_o));

  assert_align_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !op_i && little_endian_i)
      |=> (done_o && align_err_o && !invalid_o && !mem_req_valid_o));

  assert_quad_odd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i && tgt_idx_i[0])
      |=> (done_o && invalid_o && !mem_req_valid_o));

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i)
      |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_dword_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_flag_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o || align_err_o) |-> done_o);

  assert_write_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);
endmodule

bind mrl_load_seq mrl_seq_chk #(.AW(AW), .XLEN(XLEN), .IDX_W(IDX_W)) u_seq_chk (.*);

// File: tb/mrl_load_seq_tb_top.sv
module mrl_load_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int XLEN = 64;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        quad;
    logic        le;
    logic [4:0]  tgt;
    logic [4:0]  base;
    logic [31:0] addr;
    logic [1:0]  err;   // 0 ok, 1 invalid, 2 align
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 5'd28, 5'd3,  32'h0000_1000, 2'd0},  // R2 R3
    '{1'b0, 1'b0, 5'd31, 5'd5,  32'h0000_2004, 2'd0},  // R2 single
    '{1'b0, 1'b0, 5'd0,  5'd7,  32'h0000_3000, 2'd1},  // R4 tgt 0
    '{1'b0, 1'b0, 5'd20, 5'd0,  32'h0000_3000, 2'd1},  // R4 base 0
    '{1'b0, 1'b0, 5'd20, 5'd31, 32'h0000_3000, 2'd1},  // R4 top
    '{1'b0, 1'b0, 5'd20, 5'd20, 32'h0000_3000, 2'd1},  // R4 edge
    '{1'b0, 1'b0, 5'd20, 5'd19, 32'h0000_4100, 2'd0},  // R2 edge
    '{1'b0, 1'b1, 5'd20, 5'd5,  32'h0000_5000, 2'd2},  // R5
    '{1'b0, 1'b1, 5'd20, 5'd25, 32'h0000_5000, 2'd2},  // R5 precedence
    '{1'b1, 1'b0, 5'd6,  5'd3,  32'h0000_6010, 2'd0},  // R6
    '{1'b1, 1'b1, 5'd10, 5'd0,  32'h0000_7020, 2'd0},  // R7 base 0 ok
    '{1'b1, 1'b0, 5'd7,  5'd2,  32'h0000_8000, 2'd1},  // R8 odd
    '{1'b1, 1'b1, 5'd4,  5'd4,  32'h0000_8000, 2'd1},  // R8 equal
    '{1'b0, 1'b0, 5'd2,  5'd1,  32'h0001_0000, 2'd0}   // R2 long
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            op_i = 1'b0;
  logic            little_endian_i = 1'b0;
  logic [4:0]      tgt_idx_i = '0;
  logic [4:0]      base_idx_i = '0;
  logic [AW-1:0]   addr_i = '0;
  logic            mem_req_ready_i = 1'b0;
  logic            mem_rsp_valid_i = 1'b0;
  logic [XLEN-1:0] mem_rsp_data_i = '0;
  logic            busy_o, done_o, invalid_o, align_err_o;
  logic            mem_req_valid_o, mem_req_dword_o;
  logic [AW-1:0]   mem_req_addr_o;
  logic            wr_en_o;
  logic [4:0]      wr_idx_o;
  logic [XLEN-1:0] wr_data_o;

  int n_checks = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_req = 0;
  int cyc = 0;
  logic        cur_quad = 1'b0, cur_le = 1'b0;
  logic [4:0]  cur_tgt = '0;
  logic [31:0] cur_addr = '0;
  logic        stray = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrl_load_seq #(.AW(AW), .XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .little_endian_i(little_endian_i), .tgt_idx_i(tgt_idx_i),
    .base_idx_i(base_idx_i), .addr_i(addr_i), .busy_o(busy_o),
    .done_o(done_o), .invalid_o(invalid_o), .align_err_o(align_err_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_dword_o(mem_req_dword_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
  );

  function automatic logic [63:0] mem_val(input logic [31:0] a);
    return {~a ^ 32'h1f2e_3d4c, a ^ 32'h5a3c_96e1};
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = d[(7-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] beat_addr(input int k);
    return cur_addr + 32'(k * (cur_quad ? 8 : 4));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: stalls ready, varies latency
  initial begin
    logic        pend;
    int          lat;
    logic [31:0] pend_addr;
    pend = 1'b0; lat = 0; pend_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_val(pend_addr);
          pend = 1'b0;
        end else lat--;
      end
      if (stray) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = '1;
      end
      mem_req_ready_i = (cyc % 3) != 1;
      if (mem_req_valid_o && mem_req_ready_i) begin
        // R2 R6 R7: request address and size
        chk(mem_req_addr_o == beat_addr(n_req), "R2/R6 request address",
            64'(mem_req_addr_o), 64'(beat_addr(n_req)));
        chk(mem_req_dword_o == cur_quad, "R2/R6 request size",
            64'(mem_req_dword_o), 64'(cur_quad));
        pend_addr = mem_req_addr_o;
        n_req++;
        lat = n_req % 3;
        pend = 1'b1;
      end
    end
  end

  // write monitor
  initial begin
    forever begin
      @(negedge clk);
      if (wr_en_o) begin
        logic [4:0]  e_idx;
        logic [63:0] e_dat;
        logic [63:0] raw;
        raw = mem_val(beat_addr(n_wr));
        if (!cur_quad) begin
          e_idx = cur_tgt + 5'(n_wr);
          e_dat = {32'h0, raw[31:0]};
        end else if (cur_le) begin
          e_idx = cur_tgt + 5'd1 - 5'(n_wr);
          e_dat = bswap(raw);
        end else begin
          e_idx = cur_tgt + 5'(n_wr);
          e_dat = raw;
        end
        chk(wr_idx_o == e_idx, "R2/R6/R7 write index", 64'(wr_idx_o), 64'(e_idx));
        chk(wr_data_o == e_dat, "R3/R6/R7 write data", wr_data_o, e_dat);
        n_wr++;
      end
    end
  end

  task automatic run_op(input vec_t v);
    int exp_n;
    @(negedge clk);
    cur_quad = v.quad; cur_le = v.le; cur_tgt = v.tgt; cur_addr = v.addr;
    n_wr = 0; n_req = 0;
    start_i = 1'b1; op_i = v.quad; little_endian_i = v.le;
    tgt_idx_i = v.tgt; base_idx_i = v.base; addr_i = v.addr;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after start", 64'(busy_o), 64'd1);
    while (!done_o) @(negedge clk);
    chk(invalid_o == (v.err == 2'd1), "R4/R8 invalid flag", 64'(invalid_o), 64'(v.err == 2'd1));
    chk(align_err_o == (v.err == 2'd2), "R5 align flag", 64'(align_err_o), 64'(v.err == 2'd2));
    @(negedge clk);
    exp_n = (v.err != 2'd0) ? 0 : (v.quad ? 2 : 32 - int'(v.tgt));
    chk(n_wr == exp_n, "R2/R4/R5/R8 write count", 64'(n_wr), 64'(exp_n));
    chk(n_req == exp_n, "R2/R4/R5/R8 request count", 64'(n_req), 64'(exp_n));
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1/R10 idle after done", 64'({busy_o, done_o}), 64'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, invalid_o, align_err_o, mem_req_valid_o, wr_en_o} == 6'b0,
        "R1/R10 reset outputs", 64'({busy_o, done_o, invalid_o, align_err_o, mem_req_valid_o, wr_en_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_op(VECS[i]);

    // R1: start while busy is ignored
    @(negedge clk);
    cur_quad = 1'b0; cur_le = 1'b0; cur_tgt = 5'd28; cur_addr = 32'h0000_9000;
    n_wr = 0; n_req = 0;
    start_i = 1'b1; op_i = 1'b0; little_endian_i = 1'b0;
    tgt_idx_i = 5'd28; base_idx_i = 5'd3; addr_i = 32'h0000_9000;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; little_endian_i = 1'b1;
    tgt_idx_i = 5'd6; base_idx_i = 5'd3; addr_i = 32'h0000_a000;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_wr == 4, "R1 start while busy ignored (writes)", 64'(n_wr), 64'd4);
    chk(busy_o == 1'b0, "R1 no second operation", 64'(busy_o), 64'd0);

    // R9: stray response while idle is ignored
    @(negedge clk);
    n_wr = 0;
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_wr == 0 && busy_o == 1'b0, "R9 stray response ignored", 64'(n_wr), 64'd0);

    finish_run();
  end
endmodule